// File: doc/BRIEF.md
# Byte-Wide State Scan Port

This block gives software a way to save and later rebuild the internal state of a functional unit that holds 268 state flip-flops. The unit is put into scan mode by the enclosing logic while a suspend or resume sequence runs. In scan mode a single 8-bit data register, selected by an index on a byte-wide host interface, moves the state one byte per access. On a save, each read returns the next byte of a snapshot taken at the first read. On a restore, each write pushes in the next byte, and the final write loads the rebuilt vector back into the unit.

The vector is not a whole number of bytes. The final access of a pass carries only the top four state bits, in the low nibble. An internal byte position runs from 0 to 33. It returns to 0 after the last byte of a pass and whenever the scan mode input changes. No bit can be addressed directly. The order of the bytes is the only way in.

Top module: `scan_state_port`

## Requirements
- R1: After reset, `host_rdata` is 00h, `state_load` is 0, `state_out` is all zeros and the byte position is 0.
- R2: Only accesses with `host_index` equal to F1h reach the port. A strobe at any other index leaves `host_rdata` unchanged and does not advance the byte position.
- R3: A read at byte position 0 captures the whole of `state_in` and returns its bits 7..0 on `host_rdata` one cycle after the strobe. Later changes of `state_in` do not alter the bytes of that pass.
- R4: Successive reads in a pass return the captured bits in ascending order, 8 bits each: read k (k = 0..32) returns bits 8k+7..8k. The 34th read returns bits 267..264 in bits 3..0, with bits 7..4 reading 0.
- R5: After the 34th access the position is 0 again, so the next read captures `state_in` anew.
- R6: Writes collect bytes in the same ascending order. On the 34th write, bits 3..0 of that byte become state bits 267..264 and bits 7..4 are discarded. `state_out` takes the full rebuilt vector one cycle after that strobe, and `state_load` is 1 for exactly that one cycle.
- R7: `state_out` changes only together with a `state_load` pulse. Reads and incomplete write passes leave it unchanged.
- R8: While `scan_mode` is 0, `host_rdata` reads 00h from the next cycle on. Writes are ignored: they cause no load and do not advance the position.
- R9: In any cycle in which `scan_mode` differs from its value in the previous cycle, the position is forced to 0 and an access made in that same cycle is ignored.
- R10: If read and write strobes are both asserted in one valid access, only the write is performed, and `host_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_mode | input | 1 | Selects scan operation (1) or normal function (0) |
| host_index | input | 8 | Host register index |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data of the scan register |
| state_in | input | 268 | Parallel state from the functional unit |
| state_out | output | 268 | Rebuilt state to the functional unit |
| state_load | output | 1 | One-cycle strobe to load `state_out` into the unit |

## Verification
A change of the scan mode input can fall in the same cycle as a host access. In that case the mode change must win: the position returns to 0 and the access is dropped. The bench raises the mode together with a read strobe and checks that the data stays 00h and that the next read returns byte 0. It also drops the mode three bytes into a pass and shows that the following pass starts again from byte 0. Read and write strobes arriving together form a second collision. The bench provokes it on the final byte of a restore and checks that the load happens while the read data keeps its previous value.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {ACC_NONE = 2'd0, ACC_RD = 2'd1, ACC_WR = 2'd2} acc_kind_t;

  function automatic int bytes_for(input int bits, input int byte_w);
    return (bits + byte_w - 1) / byte_w;
  endfunction
endpackage

// File: rtl/scan_pos_counter.sv
module scan_pos_counter #(
  parameter int NUM_BYTES = 34,
  localparam int POS_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_mode,
  input  logic             advance,
  output logic             mode_chg,
  output logic             is_first,
  output logic             is_last,
  output logic [POS_W-1:0] pos
);
  logic mode_q;

  assign mode_chg = scan_mode ^ mode_q;
  assign is_first = (pos == '0);
  assign is_last  = (pos == POS_W'(NUM_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      pos    <= '0;
    end else begin
      mode_q <= scan_mode;
      if (mode_chg)     pos <= '0;
      else if (advance) pos <= is_last ? '0 : pos + POS_W'(1);
    end
  end

  assert_pos_range_R5: assert property (@(posedge clk) disable iff (rst)
    pos <= POS_W'(NUM_BYTES - 1));
  assert_mode_reset_R9: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (pos == '0));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (advance && is_last) |=> (pos == '0));
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int STATE_W = 268,
  parameter int DATA_W  = 8,
  localparam int NUM_BYTES = scan_pkg::bytes_for(STATE_W, DATA_W),
  localparam int CHAIN_W   = NUM_BYTES * DATA_W,
  localparam int LAST_BITS = STATE_W - (NUM_BYTES - 1) * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_rd,
  input  logic               shift_wr,
  input  logic               first,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [STATE_W-1:0] state_in,
  output logic [DATA_W-1:0]  rd_byte,
  output logic [STATE_W-1:0] load_vec
);
  logic [CHAIN_W-1:0] chain;
  logic [CHAIN_W-1:0] snap;

  always_comb begin
    snap = '0;
    snap[STATE_W-1:0] = state_in;
  end

  // A read at byte 0 takes the unit's live bits; later reads take the snapshot.
  assign rd_byte  = first ? state_in[DATA_W-1:0] : chain[DATA_W-1:0];
  // The byte in flight supplies only the bits still missing from the top.
  assign load_vec = {wdata[LAST_BITS-1:0], chain[CHAIN_W-1:DATA_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else if (shift_wr) begin
      chain <= {wdata, chain[CHAIN_W-1:DATA_W]};
    end else if (shift_rd) begin
      chain <= first ? (snap >> DATA_W) : (chain >> DATA_W);
    end
  end

  assert_one_shift_R10: assert property (@(posedge clk) disable iff (rst)
    !(shift_rd && shift_wr));
endmodule

// File: rtl/scan_state_port.sv
module scan_state_port #(
  parameter int STATE_W = 268,
  parameter int DATA_W  = 8,
  parameter int INDEX_W = 8,
  parameter logic [INDEX_W-1:0] PORT_INDEX = 8'hF1,
  localparam int NUM_BYTES = scan_pkg::bytes_for(STATE_W, DATA_W),
  localparam int POS_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scan_mode,
  input  logic [INDEX_W-1:0] host_index,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic [STATE_W-1:0] state_in,
  output logic [STATE_W-1:0] state_out,
  output logic               state_load
);
  import scan_pkg::*;

  logic             mode_chg, is_first, is_last;
  logic [POS_W-1:0] pos;
  logic             hit;
  acc_kind_t        acc;
  logic [DATA_W-1:0]  rd_byte;
  logic [STATE_W-1:0] load_vec;

  assign hit = scan_mode && !mode_chg && (host_index == PORT_INDEX);

  always_comb begin
    acc = ACC_NONE;
    if (hit && host_wr)      acc = ACC_WR;
    else if (hit && host_rd) acc = ACC_RD;
  end

  scan_pos_counter #(.NUM_BYTES(NUM_BYTES)) u_pos (
    .clk      (clk),
    .rst      (rst),
    .scan_mode(scan_mode),
    .advance  (acc != ACC_NONE),
    .mode_chg (mode_chg),
    .is_first (is_first),
    .is_last  (is_last),
    .pos      (pos)
  );

  scan_chain #(.STATE_W(STATE_W), .DATA_W(DATA_W)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .shift_rd(acc == ACC_RD),
    .shift_wr(acc == ACC_WR),
    .first   (is_first),
    .wdata   (host_wdata),
    .state_in(state_in),
    .rd_byte (rd_byte),
    .load_vec(load_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      state_out  <= '0;
      state_load <= 1'b0;
    end else begin
      state_load <= 1'b0;
      if (!scan_mode)          host_rdata <= '0;
      else if (acc == ACC_RD)  host_rdata <= rd_byte;
      if (acc == ACC_WR && is_last) begin
        state_out  <= load_vec;
        state_load <= 1'b1;
      end
    end
  end

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !scan_mode |=> (host_rdata == '0));
  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_RD && pos == '0) |=> (host_rdata == $past(state_in[DATA_W-1:0])));
  assert_load_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    state_load |=> !state_load);
  assert_load_src_R6: assert property (@(posedge clk) disable iff (rst)
    state_load |-> $past(scan_mode && host_wr));
  assert_out_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !state_load |-> $stable(state_out));
  assert_rw_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (hit && host_rd && host_wr) |=> $stable(host_rdata));
endmodule

// File: tb/scan_state_port_test.sv
`timescale 1ns/1ps
module scan_state_port_test;
  localparam int SW = 268;
  localparam int NB = 34;

  logic clk = 1'b0, rst = 1'b1, scan_mode = 1'b0;
  logic [7:0] host_index = 8'h00, host_wdata = 8'h00, host_rdata;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [SW-1:0] state_in = '0, state_out;
  logic state_load;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scan_state_port uut (
    .clk(clk), .rst(rst), .scan_mode(scan_mode), .host_index(host_index),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .state_in(state_in), .state_out(state_out),
    .state_load(state_load)
  );

  function automatic logic [SW-1:0] pattern(input int seed);
    logic [SW-1:0] v;
    for (int i = 0; i < SW; i++) v[i] = (((i * 13 + seed) % 7) < 3);
    return v;
  endfunction

  function automatic logic [7:0] byte_of(input logic [SW-1:0] v, input int k);
    if (k == NB - 1) return {4'h0, v[SW-1:SW-4]};
    return v[8*k +: 8];
  endfunction

  task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] b);
    host_index = idx; host_rd = 1'b1; cyc(); host_rd = 1'b0; b = host_rdata;
  endtask

  task automatic wr(input logic [7:0] d);
    host_index = 8'hF1; host_wdata = d; host_wr = 1'b1; cyc(); host_wr = 1'b0;
  endtask

  task automatic enter_mode();
    scan_mode = 1'b0; cyc(); cyc(); scan_mode = 1'b1; cyc();
  endtask

  task automatic t_reset();
    check("R1 rdata", SW'(host_rdata), '0);
    check("R1 load", SW'(state_load), '0);
    check("R1 state_out", state_out, '0);
  endtask

  task automatic t_read_pass();
    logic [SW-1:0] a = pattern(3), b = pattern(5);
    logic [7:0] got;
    int bad = 0;
    state_in = a; enter_mode();
    rd(8'hF1, got); check("R3 first byte", SW'(got), SW'(byte_of(a, 0)));
    state_in = b;
    rd(8'hF0, got); check("R2 other index holds", SW'(got), SW'(byte_of(a, 0)));
    for (int k = 1; k < NB; k++) begin
      rd(8'hF1, got);
      if (got !== byte_of(a, k)) bad++;
      if (k == NB - 1) check("R4 last nibble", SW'(got), SW'(byte_of(a, k)));
    end
    check("R4 ordered bytes", SW'(bad), '0);
    rd(8'hF1, got); check("R5 recapture after wrap", SW'(got), SW'(byte_of(b, 0)));
    check("R7 out unchanged by reads", state_out, '0);
  endtask

  task automatic t_write_pass();
    logic [SW-1:0] c = pattern(11);
    enter_mode();
    for (int k = 0; k < NB - 1; k++) wr(byte_of(c, k));
    check("R6 no early load", SW'(state_load), '0);
    check("R7 out held mid-pass", state_out, '0);
    wr({4'hF, c[SW-1:SW-4]});
    check("R6 load pulse", SW'(state_load), SW'(1));
    check("R6 rebuilt vector", state_out, c);
    cyc();
    check("R6 pulse one cycle", SW'(state_load), '0);
  endtask

  task automatic t_idle();
    logic [7:0] got;
    logic [SW-1:0] keep = state_out;
    int loads = 0;
    scan_mode = 1'b0; cyc(); cyc();
    rd(8'hF1, got); check("R8 idle reads zero", SW'(got), '0);
    for (int k = 0; k < NB; k++) begin wr(8'h5A); loads += state_load; end
    cyc();
    check("R8 idle writes no load", SW'(loads), '0);
    check("R8 idle writes keep out", state_out, keep);
  endtask

  task automatic t_mode_collision();
    logic [SW-1:0] a = pattern(17);
    logic [7:0] got;
    state_in = a; scan_mode = 1'b0; cyc();
    scan_mode = 1'b1; host_index = 8'hF1; host_rd = 1'b1; cyc(); host_rd = 1'b0;
    check("R9 access on mode edge ignored", SW'(host_rdata), '0);
    rd(8'hF1, got); check("R9 next read is byte 0", SW'(got), SW'(byte_of(a, 0)));
    rd(8'hF1, got); rd(8'hF1, got);
    check("R4 third byte", SW'(got), SW'(byte_of(a, 2)));
    scan_mode = 1'b0; host_rd = 1'b1; cyc(); host_rd = 1'b0;
    check("R8 rdata zero on exit", SW'(host_rdata), '0);
    scan_mode = 1'b1; cyc();
    rd(8'hF1, got); check("R9 pass restarts", SW'(got), SW'(byte_of(a, 0)));
  endtask

  task automatic t_rw_collision();
    logic [SW-1:0] a = pattern(23), d = pattern(29);
    logic [7:0] got;
    state_in = a; enter_mode();
    for (int k = 0; k < NB; k++) rd(8'hF1, got);
    check("R4 last byte before collision", SW'(got), SW'(byte_of(a, NB - 1)));
    for (int k = 0; k < NB - 1; k++) wr(byte_of(d, k));
    host_index = 8'hF1; host_wdata = byte_of(d, NB - 1);
    host_rd = 1'b1; host_wr = 1'b1; cyc(); host_rd = 1'b0; host_wr = 1'b0;
    check("R10 rdata held", SW'(host_rdata), SW'(byte_of(a, NB - 1)));
    check("R10 write performed", SW'(state_load), SW'(1));
    check("R10 vector", state_out, d);
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst = 1'b0; cyc();
    t_reset();
    t_read_pass();
    t_write_pass();
    t_idle();
    t_mode_collision();
    t_rw_collision();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule